// File: doc/BRIEF.md
# DDR2 Command Timing Guard

This block watches the decoded command stream that a memory controller sends to one rank of an eight-bank DDR2 device. For each command it decides whether issuing that command in that cycle would break one of the device's inter-command timing rules or its bank open/closed rules. It returns a one-bit legal flag and a four-bit violation code one clock later. Internally it tracks which banks hold an open row, how long ago each bank was activated, and how long each bank must still wait before it may be precharged or activated again. Rank-wide limits are also tracked: activate spacing, CAS spacing, write-to-read turnaround, mode-register settling, and a rolling window that allows at most four activates.

All limits are parameters counted in clock cycles. The defaults are the nanosecond limits rounded up at a 3.0 ns clock: RCD 5, RAS 14, RC 19, RRD 3, FAW 13, WR 5, RP 5, WTR 3, RTP 3, CCD 2, MRD 2, with CAS latency 5 and burst length 8. Write-side delays count from the last data beat of the write burst. That beat ends WL + BL/2 cycles after the write command, where WL = CL - 1. A command that is flagged is treated as never issued and leaves every tracked state unchanged. It is meant for a controller bench or for an on-chip guard in front of the PHY.

Top module: `ddr2_timing_guard`

## Requirements
- R1: When `cmd_vld` is high in cycle t, `res_vld` is high in cycle t+1, with `res_ok` = 1 exactly when `res_code` = 0. With no command, `res_vld` is low. After reset `res_vld` = 0, `res_ok` = 1 and `res_code` = 0. Command codes on `cmd_op` are: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 mode load, 7 reserved.
- R2: The block reports code 2 (bank state) for a read or write to a closed bank, for an activate to an open bank, and for a mode load while any bank is open. A precharge to a closed bank is legal.
- R3: A read or write less than T_RCD cycles after the activate of its bank gives code 3.
- R4: An activate less than T_RC cycles after the previous activate of the same bank gives code 4.
- R5: An activate less than T_RRD cycles after the last accepted activate to any bank gives code 5.
- R6: A fifth activate within any T_FAW-cycle window gives code 6.
- R7: A read or write less than T_CCD cycles after the last accepted read or write gives code 7.
- R8: A read less than CL-1+BL/2+T_WTR cycles after the last accepted write gives code 8.
- R9: A precharge, or a precharge-all covering an open bank, gives code 9 when that bank was activated less than T_RAS cycles earlier. It gives code 13 when the activate was more than T_RAS_MAX cycles earlier.
- R10: A precharge less than BL/2-2+max(T_RTP,2) cycles after a read to that bank gives code 10.
- R11: A precharge less than CL-1+BL/2+T_WR cycles after a write to that bank gives code 11.
- R12: Any command other than a no-op or reserved code, less than T_MRD cycles after an accepted mode load, gives code 1. An activate to a bank still recovering from a precharge gives code 12. That recovery lasts T_RP cycles after a precharge and T_RP+1 cycles after a precharge-all.
- R13: A read or write with `cmd_ap` set closes its bank at once. A re-activate of that bank then needs CL-1+BL/2+T_WR+T_RP cycles after the write, or BL/2-2+max(T_RTP,2)+T_RP cycles after the read. An earlier re-activate gives code 12.
- R14: When several rules are broken, the smallest code is reported. A flagged command changes no tracked state. No-op and reserved codes are always legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code |
| cmd_bank | input | BA_W | Target bank |
| cmd_ap | input | 1 | Auto-precharge bit on read or write |
| res_vld | output | 1 | Verdict for the previous cycle's command |
| res_ok | output | 1 | Previous command was legal |
| res_code | output | 4 | Violation code, 0 when legal |

## Verification
Several rules are checked on every cycle by the assertions: an accepted activate opens its bank and an accepted precharge closes it, a read or write to a closed bank is always refused, a CAS right after an accepted CAS and any command right after a mode load are refused, and no verdict appears without a command. Those properties only see one-cycle distances. The exact cycle at which each multi-cycle limit expires, the four-activate window, the auto-precharge recovery lengths, the priority among codes and the rule that refused commands leave no trace can only be shown by the bench's gap sweeps. Each sweep steps the spacing across the limit and compares the result with the limit computed from the parameters.

// File: rtl/ddr2g_pkg.sv
package ddr2g_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_PREA = 3'd5,
    OP_MRS  = 3'd6,
    OP_RSV  = 3'd7
  } op_e;

  typedef enum logic [3:0] {
    V_NONE   = 4'd0,
    V_MRD    = 4'd1,
    V_STATE  = 4'd2,
    V_RCD    = 4'd3,
    V_RC     = 4'd4,
    V_RRD    = 4'd5,
    V_FAW    = 4'd6,
    V_CCD    = 4'd7,
    V_WTR    = 4'd8,
    V_RAS    = 4'd9,
    V_RTP    = 4'd10,
    V_WREC   = 4'd11,
    V_RP     = 4'd12,
    V_RASMAX = 4'd13
  } vcode_e;

  // Cycles from a write command to the end of its last data beat.
  function automatic int wr_burst_end(int cl, int bl);
    return (cl - 1) + bl / 2;
  endfunction

  // Cycles from a read command to the earliest legal precharge.
  function automatic int rd_to_pre(int bl, int rtp);
    return bl / 2 - 2 + ((rtp > 2) ? rtp : 2);
  endfunction

  // Value loaded into a down counter so that it clears after n cycles.
  function automatic int load_of(int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int bits_for(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/ddr2g_dcount.sv
module ddr2g_dcount #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ddr2g_bank.sv
module ddr2g_bank
  import ddr2g_pkg::*;
#(
  parameter int T_RP    = 5,
  parameter int N_RTP   = 5,
  parameter int N_WREC  = 13,
  parameter int N_DAL   = 18,
  parameter int N_RDAP  = 10,
  parameter int N_RPA   = 6,
  parameter int AGE_MAX = 100,
  parameter int AW      = 7,
  parameter int CW      = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  op_e           op,
  input  logic          ap,
  input  logic          pall,
  output logic          open_o,
  output logic [AW-1:0] age_o,
  output logic          rtp_busy,
  output logic          wrec_busy,
  output logic          act_busy
);
  localparam logic [CW-1:0] L_RP   = CW'(load_of(T_RP));
  localparam logic [CW-1:0] L_RTP  = CW'(load_of(N_RTP));
  localparam logic [CW-1:0] L_WREC = CW'(load_of(N_WREC));
  localparam logic [CW-1:0] L_DAL  = CW'(load_of(N_DAL));
  localparam logic [CW-1:0] L_RDAP = CW'(load_of(N_RDAP));
  localparam logic [CW-1:0] L_RPA  = CW'(load_of(N_RPA));
  localparam logic [AW-1:0] A_MAX  = AW'(AGE_MAX);

  logic          is_open;
  logic [AW-1:0] age;
  logic          ev_act, ev_rd, ev_wr, ev_pre, ev_auto;
  logic          blk_load;
  logic [CW-1:0] blk_val;

  assign ev_act  = hit && (op == OP_ACT);
  assign ev_rd   = hit && (op == OP_RD);
  assign ev_wr   = hit && (op == OP_WR);
  assign ev_pre  = hit && (op == OP_PRE) && is_open;
  assign ev_auto = (ev_rd || ev_wr) && ap;

  always_ff @(posedge clk) begin
    if (!rst_n)                          is_open <= 1'b0;
    else if (ev_act)                     is_open <= 1'b1;
    else if (ev_pre || ev_auto || pall)  is_open <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             age <= A_MAX;
    else if (ev_act)        age <= AW'(1);
    else if (age < A_MAX)   age <= age + 1'b1;
  end

  always_comb begin
    blk_load = 1'b1;
    blk_val  = L_RP;
    if (ev_wr && ap)          blk_val = L_DAL;
    else if (ev_rd && ap)     blk_val = L_RDAP;
    else if (ev_pre)          blk_val = L_RP;
    else if (pall && is_open) blk_val = L_RPA;
    else                      blk_load = 1'b0;
  end

  ddr2g_dcount #(.W(CW)) u_rtp (
    .clk(clk), .rst_n(rst_n), .load(ev_rd), .val(L_RTP), .busy(rtp_busy)
  );
  ddr2g_dcount #(.W(CW)) u_wrec (
    .clk(clk), .rst_n(rst_n), .load(ev_wr), .val(L_WREC), .busy(wrec_busy)
  );
  ddr2g_dcount #(.W(CW)) u_blk (
    .clk(clk), .rst_n(rst_n), .load(blk_load), .val(blk_val), .busy(act_busy)
  );

  assign open_o = is_open;
  assign age_o  = age;
endmodule

// File: rtl/ddr2g_rank.sv
module ddr2g_rank
  import ddr2g_pkg::*;
#(
  parameter int T_RRD = 3,
  parameter int T_CCD = 2,
  parameter int N_WTR = 11,
  parameter int T_MRD = 2,
  parameter int T_FAW = 13,
  parameter int FAW_N = 4,
  parameter int CW    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_acc,
  input  logic cas_acc,
  input  logic wr_acc,
  input  logic mrs_acc,
  output logic rrd_busy,
  output logic ccd_busy,
  output logic wtr_busy,
  output logic mrd_busy,
  output logic faw_full
);
  ddr2g_dcount #(.W(CW)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(act_acc), .val(CW'(load_of(T_RRD))), .busy(rrd_busy)
  );
  ddr2g_dcount #(.W(CW)) u_ccd (
    .clk(clk), .rst_n(rst_n), .load(cas_acc), .val(CW'(load_of(T_CCD))), .busy(ccd_busy)
  );
  ddr2g_dcount #(.W(CW)) u_wtr (
    .clk(clk), .rst_n(rst_n), .load(wr_acc), .val(CW'(load_of(N_WTR))), .busy(wtr_busy)
  );
  ddr2g_dcount #(.W(CW)) u_mrd (
    .clk(clk), .rst_n(rst_n), .load(mrs_acc), .val(CW'(load_of(T_MRD))), .busy(mrd_busy)
  );

  // Rolling activate window: one slot per activate still inside the window.
  logic [FAW_N-1:0] slot_busy;
  logic [FAW_N-1:0] pick_oh;

  assign pick_oh  = ~slot_busy & (slot_busy + 1'b1);
  assign faw_full = &slot_busy;

  for (genvar i = 0; i < FAW_N; i++) begin : g_slot
    ddr2g_dcount #(.W(CW)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(act_acc && pick_oh[i]),
      .val(CW'(load_of(T_FAW))), .busy(slot_busy[i])
    );
  end
endmodule

// File: rtl/ddr2_timing_guard.sv
module ddr2_timing_guard
  import ddr2g_pkg::*;
#(
  parameter int BA_W      = 3,
  parameter int CL        = 5,
  parameter int BL        = 8,
  parameter int T_RCD     = 5,
  parameter int T_RAS     = 14,
  parameter int T_RAS_MAX = 23334,
  parameter int T_RC      = 19,
  parameter int T_RRD     = 3,
  parameter int T_FAW     = 13,
  parameter int FAW_N     = 4,
  parameter int T_CCD     = 2,
  parameter int T_WTR     = 3,
  parameter int T_RTP     = 3,
  parameter int T_WR      = 5,
  parameter int T_RP      = 5,
  parameter int T_MRD     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_vld,
  input  logic [2:0]      cmd_op,
  input  logic [BA_W-1:0] cmd_bank,
  input  logic            cmd_ap,
  output logic            res_vld,
  output logic            res_ok,
  output logic [3:0]      res_code
);
  localparam int NB      = 2 ** BA_W;
  localparam int WR_END  = wr_burst_end(CL, BL);
  localparam int N_WTR   = WR_END + T_WTR;
  localparam int N_WREC  = WR_END + T_WR;
  localparam int N_DAL   = N_WREC + T_RP;
  localparam int N_RTP   = rd_to_pre(BL, T_RTP);
  localparam int N_RDAP  = N_RTP + T_RP;
  localparam int N_RPA   = T_RP + 1;
  localparam int AGE_MAX = max2(T_RAS_MAX + 1, max2(T_RC, max2(T_RCD, T_RAS)));
  localparam int AW      = bits_for(AGE_MAX);
  localparam int CMAX    = max2(max2(N_DAL, N_RDAP), max2(max2(N_WTR, T_FAW),
                                max2(max2(T_RRD, T_CCD), max2(T_MRD, N_RPA))));
  localparam int CW      = bits_for(CMAX);

  localparam logic [AW-1:0] A_RCD = AW'(T_RCD);
  localparam logic [AW-1:0] A_RAS = AW'(T_RAS);
  localparam logic [AW-1:0] A_RC  = AW'(T_RC);
  localparam logic [AW-1:0] A_MAX = AW'(T_RAS_MAX);

  op_e             op;
  logic [NB-1:0]   bank_open;
  logic [AW-1:0]   age_v [NB];
  logic [NB-1:0]   rtp_v, wrec_v, blk_v;
  logic [NB-1:0]   ras_short_v, ras_long_v;
  logic [NB-1:0]   hit_v;
  logic            rrd_busy, ccd_busy, wtr_busy, mrd_busy, faw_full;
  vcode_e          v_code;
  logic            accept;
  logic            act_acc, cas_acc, wr_acc, mrs_acc, pre_acc, pall_acc;
  logic            tgt_open;
  logic [AW-1:0]   tgt_age;

  assign op       = op_e'(cmd_op);
  assign tgt_open = bank_open[cmd_bank];
  assign tgt_age  = age_v[cmd_bank];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign hit_v[b] = accept && (cmd_bank == BA_W'(b)) &&
                      (op == OP_ACT || op == OP_RD || op == OP_WR || op == OP_PRE);
    assign ras_short_v[b] = bank_open[b] && (age_v[b] < A_RAS);
    assign ras_long_v[b]  = bank_open[b] && (age_v[b] > A_MAX);

    ddr2g_bank #(
      .T_RP(T_RP), .N_RTP(N_RTP), .N_WREC(N_WREC), .N_DAL(N_DAL),
      .N_RDAP(N_RDAP), .N_RPA(N_RPA), .AGE_MAX(AGE_MAX), .AW(AW), .CW(CW)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .hit(hit_v[b]), .op(op), .ap(cmd_ap),
      .pall(pall_acc), .open_o(bank_open[b]), .age_o(age_v[b]),
      .rtp_busy(rtp_v[b]), .wrec_busy(wrec_v[b]), .act_busy(blk_v[b])
    );
  end

  ddr2g_rank #(
    .T_RRD(T_RRD), .T_CCD(T_CCD), .N_WTR(N_WTR), .T_MRD(T_MRD),
    .T_FAW(T_FAW), .FAW_N(FAW_N), .CW(CW)
  ) u_rank (
    .clk(clk), .rst_n(rst_n), .act_acc(act_acc), .cas_acc(cas_acc),
    .wr_acc(wr_acc), .mrs_acc(mrs_acc), .rrd_busy(rrd_busy),
    .ccd_busy(ccd_busy), .wtr_busy(wtr_busy), .mrd_busy(mrd_busy),
    .faw_full(faw_full)
  );

  // Verdict: rules are tested in rising code order, first hit wins.
  always_comb begin
    v_code = V_NONE;
    unique case (op)
      OP_ACT: begin
        if (mrd_busy)               v_code = V_MRD;
        else if (tgt_open)          v_code = V_STATE;
        else if (tgt_age < A_RC)    v_code = V_RC;
        else if (rrd_busy)          v_code = V_RRD;
        else if (faw_full)          v_code = V_FAW;
        else if (blk_v[cmd_bank])   v_code = V_RP;
      end
      OP_RD, OP_WR: begin
        if (mrd_busy)                       v_code = V_MRD;
        else if (!tgt_open)                 v_code = V_STATE;
        else if (tgt_age < A_RCD)           v_code = V_RCD;
        else if (ccd_busy)                  v_code = V_CCD;
        else if (op == OP_RD && wtr_busy)   v_code = V_WTR;
      end
      OP_PRE: begin
        if (mrd_busy)                            v_code = V_MRD;
        else if (ras_short_v[cmd_bank])          v_code = V_RAS;
        else if (tgt_open && rtp_v[cmd_bank])    v_code = V_RTP;
        else if (tgt_open && wrec_v[cmd_bank])   v_code = V_WREC;
        else if (ras_long_v[cmd_bank])           v_code = V_RASMAX;
      end
      OP_PREA: begin
        if (mrd_busy)                         v_code = V_MRD;
        else if (|ras_short_v)                v_code = V_RAS;
        else if (|(bank_open & rtp_v))        v_code = V_RTP;
        else if (|(bank_open & wrec_v))       v_code = V_WREC;
        else if (|ras_long_v)                 v_code = V_RASMAX;
      end
      OP_MRS: begin
        if (mrd_busy)          v_code = V_MRD;
        else if (|bank_open)   v_code = V_STATE;
      end
      default: v_code = V_NONE;
    endcase
  end

  assign accept   = cmd_vld && (v_code == V_NONE);
  assign act_acc  = accept && (op == OP_ACT);
  assign cas_acc  = accept && (op == OP_RD || op == OP_WR);
  assign wr_acc   = accept && (op == OP_WR);
  assign mrs_acc  = accept && (op == OP_MRS);
  assign pre_acc  = accept && (op == OP_PRE);
  assign pall_acc = accept && (op == OP_PREA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_ok   <= 1'b1;
      res_code <= 4'd0;
    end else begin
      res_vld  <= cmd_vld;
      res_ok   <= !cmd_vld || (v_code == V_NONE);
      res_code <= cmd_vld ? v_code : V_NONE;
    end
  end
endmodule

// File: rtl/ddr2_timing_guard_chk.sv
module ddr2_timing_guard_chk #(
  parameter int BA_W  = 3,
  parameter int NB    = 8,
  parameter int T_CCD = 2,
  parameter int T_MRD = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_vld,
  input logic [2:0]      cmd_op,
  input logic [BA_W-1:0] cmd_bank,
  input logic            res_vld,
  input logic            res_ok,
  input logic [3:0]      res_code,
  input logic [NB-1:0]   bank_open,
  input logic            act_acc,
  input logic            pre_acc,
  input logic            cas_acc,
  input logic            mrs_acc
);
  logic cas_d, mrs_d;
  logic is_cas, is_real;

  assign is_cas  = (cmd_op == 3'd2) || (cmd_op == 3'd3);
  assign is_real = (cmd_op != 3'd0) && (cmd_op != 3'd7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cas_d <= 1'b0;
      mrs_d <= 1'b0;
    end else begin
      cas_d <= cas_acc;
      mrs_d <= mrs_acc;
    end
  end

  // R1: no verdict without a command
  a_r1_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> !res_vld);

  // R1: an accepted activate leaves its bank open
  a_r1_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    act_acc |=> bank_open[$past(cmd_bank)]);

  // R2: a column command to a closed bank is refused
  a_r2_closed_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && is_cas && !bank_open[cmd_bank]) |=> (res_vld && !res_ok));

  // R9: an accepted precharge leaves its bank closed
  a_r9_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    pre_acc |=> !bank_open[$past(cmd_bank)]);

  if (T_CCD >= 2) begin : g_ccd
    // R7: column commands on consecutive cycles
    a_r7_ccd_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_d && cmd_vld && is_cas) |=> !res_ok);
  end

  if (T_MRD >= 2) begin : g_mrd
    // R12: any real command right after a mode load
    a_r12_mrd_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
      (mrs_d && cmd_vld && is_real) |=> (res_code == 4'd1));
  end
endmodule

bind ddr2_timing_guard ddr2_timing_guard_chk #(
  .BA_W(BA_W), .NB(NB), .T_CCD(T_CCD), .T_MRD(T_MRD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .res_vld(res_vld), .res_ok(res_ok),
  .res_code(res_code), .bank_open(bank_open), .act_acc(act_acc),
  .pre_acc(pre_acc), .cas_acc(cas_acc), .mrs_acc(mrs_acc)
);

// File: tb/sim_ddr2_timing_guard.sv
module sim_ddr2_timing_guard;
  localparam int CLK_P = 10;

  localparam int B_CL = 5, B_BL = 8, B_RCD = 5, B_RAS = 14, B_RASMAX = 60;
  localparam int B_RC = 19, B_RRD = 3, B_FAW = 13, B_CCD = 2, B_WTR = 3;
  localparam int B_RTP = 3, B_WR = 5, B_RP = 5, B_MRD = 2;

  // Limits restated from the requirements.
  localparam int E_WEND = B_BL / 2 + B_CL - 1;
  localparam int E_WTR  = E_WEND + B_WTR;
  localparam int E_WREC = E_WEND + B_WR;
  localparam int E_DAL  = E_WREC + B_RP;
  localparam int E_RTP  = (B_RTP > 2 ? B_RTP : 2) + B_BL / 2 - 2;
  localparam int E_RDAP = E_RTP + B_RP;
  localparam int E_RPA  = B_RP + 1;

  localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, PREA = 5, MRS = 6, RSV = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_vld = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic       cmd_ap = 1'b0;
  logic       res_vld, res_ok;
  logic [3:0] res_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_P / 2) clk = ~clk;

  ddr2_timing_guard #(
    .BA_W(3), .CL(B_CL), .BL(B_BL), .T_RCD(B_RCD), .T_RAS(B_RAS),
    .T_RAS_MAX(B_RASMAX), .T_RC(B_RC), .T_RRD(B_RRD), .T_FAW(B_FAW),
    .FAW_N(4), .T_CCD(B_CCD), .T_WTR(B_WTR), .T_RTP(B_RTP), .T_WR(B_WR),
    .T_RP(B_RP), .T_MRD(B_MRD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .res_vld(res_vld),
    .res_ok(res_ok), .res_code(res_code)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic gap(input int k);
    tick(k - 1);
  endtask

  task automatic do_reset();
    cmd_vld = 1'b0;
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic issue(input logic [2:0] op, input int bank, input logic ap,
                       input int exp, input string rq);
    cmd_vld = 1'b1;
    cmd_op = op;
    cmd_bank = 3'(bank);
    cmd_ap = ap;
    @(negedge clk);
    n_chk++;
    if (res_vld !== 1'b1 || res_code !== 4'(exp) || res_ok !== (exp == 0)) begin
      n_fail++;
      $display("FAIL %s: op %0d bank %0d got vld=%0b ok=%0b code=%0d, expected vld=1 ok=%0b code=%0d",
               rq, op, bank, res_vld, res_ok, res_code, (exp == 0), exp);
    end
    cmd_vld = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1: reset state and silence without commands
    tick(2);
    n_chk++;
    if (res_vld !== 1'b0 || res_ok !== 1'b1 || res_code !== 4'd0) begin
      n_fail++;
      $display("FAIL R1: after reset vld=%0b ok=%0b code=%0d, expected 0 1 0", res_vld, res_ok, res_code);
    end

    // R3: activate to column command spacing
    for (int k = 1; k <= 8; k++) begin
      do_reset();
      issue(ACT, 2, 0, 0, "R3");
      gap(k);
      issue(RD, 2, 0, (k >= B_RCD) ? 0 : 3, "R3");
    end

    // R9: minimum row-open time
    for (int k = 12; k <= 15; k++) begin
      do_reset();
      issue(ACT, 1, 0, 0, "R9");
      gap(k);
      issue(PRE, 1, 0, (k >= B_RAS) ? 0 : 9, "R9");
    end

    // R9: maximum row-open time
    for (int k = B_RASMAX - 1; k <= B_RASMAX + 2; k++) begin
      do_reset();
      issue(ACT, 5, 0, 0, "R9");
      gap(k);
      issue(PRE, 5, 0, (k <= B_RASMAX) ? 0 : 13, "R9");
    end

    // R4: same-bank activate period
    for (int k = 3; k <= 5; k++) begin
      do_reset();
      issue(ACT, 0, 0, 0, "R4");
      gap(B_RAS);
      issue(PRE, 0, 0, 0, "R4");
      gap(k);
      issue(ACT, 0, 0, (B_RAS + k >= B_RC) ? 0 : 4, "R4");
    end

    // R12: precharge recovery before activate
    for (int j = 3; j <= 6; j++) begin
      do_reset();
      issue(ACT, 0, 0, 0, "R12");
      gap(20);
      issue(PRE, 0, 0, 0, "R12");
      gap(j);
      issue(ACT, 0, 0, (j >= B_RP) ? 0 : 12, "R12");
    end

    // R5: activate spacing across banks
    for (int k = 1; k <= 4; k++) begin
      do_reset();
      issue(ACT, 0, 0, 0, "R5");
      gap(k);
      issue(ACT, 1, 0, (k >= B_RRD) ? 0 : 5, "R5");
    end

    // R6: four-activate window
    for (int j = 3; j <= 5; j++) begin
      do_reset();
      for (int b = 0; b < 4; b++) begin
        issue(ACT, b, 0, 0, "R6");
        if (b < 3) gap(B_RRD);
      end
      gap(j);
      issue(ACT, 4, 0, (3 * B_RRD + j >= B_FAW) ? 0 : 6, "R6");
    end

    // R7: column command spacing
    for (int k = 1; k <= 3; k++) begin
      do_reset();
      issue(ACT, 3, 0, 0, "R7");
      gap(B_RCD);
      issue(RD, 3, 0, 0, "R7");
      gap(k);
      issue(RD, 3, 0, (k >= B_CCD) ? 0 : 7, "R7");
    end

    // R8: write-to-read turnaround from end of burst
    for (int k = E_WTR - 2; k <= E_WTR + 1; k++) begin
      do_reset();
      issue(ACT, 6, 0, 0, "R8");
      gap(B_RCD);
      issue(WR, 6, 0, 0, "R8");
      gap(k);
      issue(RD, 6, 0, (k >= E_WTR) ? 0 : 8, "R8");
    end

    // R11: write recovery before precharge
    for (int k = E_WREC - 2; k <= E_WREC + 1; k++) begin
      do_reset();
      issue(ACT, 7, 0, 0, "R11");
      gap(B_RCD);
      issue(WR, 7, 0, 0, "R11");
      gap(k);
      issue(PRE, 7, 0, (k >= E_WREC) ? 0 : 11, "R11");
    end

    // R10: read to precharge
    for (int k = E_RTP - 2; k <= E_RTP + 1; k++) begin
      do_reset();
      issue(ACT, 4, 0, 0, "R10");
      gap(B_RAS);
      issue(RD, 4, 0, 0, "R10");
      gap(k);
      issue(PRE, 4, 0, (k >= E_RTP) ? 0 : 10, "R10");
    end

    // R13: write with auto-precharge
    for (int k = E_DAL - 2; k <= E_DAL + 1; k++) begin
      do_reset();
      issue(ACT, 0, 0, 0, "R13");
      gap(B_RCD);
      issue(WR, 0, 1, 0, "R13");
      gap(k);
      issue(ACT, 0, 0, (k >= E_DAL) ? 0 : 12, "R13");
    end
    do_reset();
    issue(ACT, 0, 0, 0, "R13");
    gap(B_RCD);
    issue(WR, 0, 1, 0, "R13");
    gap(B_CCD);
    issue(RD, 0, 0, 2, "R13");

    // R13: read with auto-precharge
    for (int k = E_RDAP - 1; k <= E_RDAP; k++) begin
      do_reset();
      issue(ACT, 2, 0, 0, "R13");
      gap(B_RAS);
      issue(RD, 2, 1, 0, "R13");
      gap(k);
      issue(ACT, 2, 0, (k >= E_RDAP) ? 0 : 12, "R13");
    end

    // R12: mode-load settling
    for (int k = 1; k <= 3; k++) begin
      do_reset();
      issue(MRS, 0, 0, 0, "R12");
      gap(k);
      issue(ACT, 0, 0, (k >= B_MRD) ? 0 : 1, "R12");
    end

    // R2: bank state rules
    do_reset();
    issue(RD, 1, 0, 2, "R2");
    issue(PRE, 1, 0, 0, "R2");
    issue(ACT, 1, 0, 0, "R2");
    gap(B_RC + 1);
    issue(ACT, 1, 0, 2, "R2");
    issue(MRS, 0, 0, 2, "R2");

    // R9 / R12: precharge-all covering a young bank, then recovery
    for (int k = E_RPA - 1; k <= E_RPA; k++) begin
      do_reset();
      issue(ACT, 0, 0, 0, "R9");
      gap(B_RRD);
      issue(ACT, 1, 0, 0, "R9");
      gap(B_RAS - 2);
      issue(PREA, 0, 0, 9, "R9");
      gap(2);
      issue(PREA, 0, 0, 0, "R9");
      gap(k);
      issue(ACT, 0, 0, (k >= E_RPA) ? 0 : 12, "R12");
    end

    // R14: refused command leaves no state, priority, no-op codes
    do_reset();
    issue(ACT, 0, 0, 0, "R14");
    issue(ACT, 1, 0, 5, "R14");
    gap(10);
    issue(RD, 1, 0, 2, "R14");
    issue(NOP, 0, 0, 0, "R14");
    issue(RSV, 3, 1, 0, "R14");
    issue(MRS, 0, 0, 2, "R14");
    do_reset();
    issue(MRS, 0, 0, 0, "R14");
    issue(RD, 2, 0, 1, "R14");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule